// File: doc/BRIEF.md
# Step-wise Restoring Divider

This block carries out unsigned integer division in pieces, under the control of a short sequence of commands. A load command stores the divisor and the upper part of the dividend. It clears the quotient and applies one reduction step at once. The controller then issues step commands. Each step pulls bits from a low-order dividend word into the working remainder, one bit per clock, until the remainder reaches the divisor or no bits are left. The step ends with a single reduction.

A reduction finds the largest power-of-two multiple of the divisor that still fits in the remainder. It does this by aligning the leading ones of the two values and stepping back one position if the aligned divisor is too large. It then subtracts that multiple and adds the matching power of two to the quotient. Each step reports how many low-order bits are still waiting. A controller can therefore unroll steps freely: a step issued after the count has reached zero leaves the state untouched. A zero flag, enabled per command, marks the end of the division. A separate output reports a zero divisor.

Top module: `stepdiv_core`

## Requirements
- R1: After reset, quotient, remainder, remaining count, zero flag, divide-by-zero error and busy are all zero.
- R2: A load command (op code 0) is accepted while idle. On the next clock edge the block stores the divisor, sets the quotient to zero and the remainder to the upper dividend, and applies one reduction. Busy stays low.
- R3: A reduction does nothing when the divisor is zero or larger than the remainder. Otherwise it subtracts the divisor shifted left by the largest amount that keeps it at or below the remainder, and adds 1 shifted by the same amount to the quotient.
- R4: A step command (op code 1) with a nonzero count raises busy from the next cycle. Each busy cycle in which the remainder is below the divisor and the count is nonzero does four things: it shifts the remainder left by one, moves bit (count-1) of the low word into bit 0, doubles the quotient and lowers the count by one. The first busy cycle without such a shift applies one reduction and ends busy. A step therefore holds busy for k+1 cycles, where k is the number of bits shifted in.
- R5: The remaining count output never rises while busy. At the end of a step it holds the number of low-word bits not yet taken.
- R6: A step command with a count of zero leaves the quotient and remainder unchanged, drives the count output to zero and does not raise busy.
- R7: When the step's zero-flag enable is 1, the zero flag is set if the final count is zero and cleared otherwise. When the enable is 0, the flag keeps its value.
- R8: A load command with a zero divisor sets the error output on the next edge, with quotient zero and remainder equal to the upper dividend. The error output holds until the next load command.
- R9: Commands presented while busy is high are ignored.
- R10: Start with a load of upper dividend zero and divisor d. Then issue steps, each with the count returned by the previous one (the first with count W), until the count is zero. The quotient and remainder then equal lo/d and lo%d, for any d below 2^(W-1).
- R11: A step count above W is treated as W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 0 = load, 1 = step |
| src_hi | input | W | Upper dividend for a load |
| divisor_in | input | W | Divisor for a load |
| src_lo | input | W | Low-order dividend word for a step |
| count_in | input | CW | Bits still to pull in for a step |
| zflag_en | input | 1 | Step updates the zero flag |
| busy | output | 1 | Step in progress |
| quotient | output | W | Quotient register |
| remainder | output | W | Remainder register |
| count_out | output | CW | Remaining bit count |
| zero_flag | output | 1 | Set when a step finishes with count zero |
| div_zero_err | output | 1 | Last load had a zero divisor |

## Verification
The results of a load command and of a zero-count step are due on the first clock edge after acceptance. A step that shifts in k bits holds busy for k+1 cycles and shows its results on the edge where busy falls. The bench model computes k for each accepted command and counts busy down one cycle at a time. On every falling clock edge it checks busy against that countdown, and it compares the data outputs whenever its own countdown says the block is idle. Commands presented during the countdown are dropped by the model in the same way the block must drop them.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } stepdiv_state_e;

    localparam logic OP_LOAD = 1'b0;
    localparam logic OP_STEP = 1'b1;
endpackage

// File: rtl/stepdiv_reduce.sv
// One reduction: subtract the largest fitting power-of-two multiple of the divisor.
module stepdiv_reduce #(
    parameter int W = 64
) (
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] dvs_i,
    output logic         hit_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int LW = (W > 1) ? $clog2(W) : 1;

    function automatic logic [LW-1:0] lead_pos(input logic [W-1:0] v);
        lead_pos = '0;
        for (int i = 0; i < W; i++) begin
            if (v[i]) lead_pos = LW'(i);
        end
    endfunction

    logic [LW-1:0] sh_amt;
    logic [W-1:0]  aligned;
    logic [W-1:0]  qbit;

    always_comb begin
        hit_o   = (dvs_i != '0) && (dvs_i <= rem_i);
        sh_amt  = lead_pos(rem_i) - lead_pos(dvs_i);
        aligned = dvs_i << sh_amt;
        qbit    = {{(W-1){1'b0}}, 1'b1} << sh_amt;
        if (aligned > rem_i) begin
            aligned = aligned >> 1;
            qbit    = qbit >> 1;
        end
        quo_o = hit_o ? (quo_i + qbit) : quo_i;
        rem_o = hit_o ? (rem_i - aligned) : rem_i;
    end
endmodule

// File: rtl/stepdiv_shift.sv
// One shift-in iteration of a step command.
module stepdiv_shift #(
    parameter int W  = 64,
    parameter int CW = 7
) (
    input  logic [W-1:0]  quo_i,
    input  logic [W-1:0]  rem_i,
    input  logic [W-1:0]  dvs_i,
    input  logic [W-1:0]  lo_i,
    input  logic [CW-1:0] cnt_i,
    output logic          go_o,
    output logic [W-1:0]  quo_o,
    output logic [W-1:0]  rem_o,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] idx;
    logic [W-1:0]  lo_sh;

    always_comb begin
        go_o  = (rem_i < dvs_i) && (cnt_i != '0);
        idx   = cnt_i - CW'(1);
        lo_sh = lo_i >> idx;
        rem_o = {rem_i[W-2:0], lo_sh[0]};
        quo_o = {quo_i[W-2:0], 1'b0};
        cnt_o = cnt_i - CW'(1);
    end
endmodule

// File: rtl/stepdiv_core.sv
module stepdiv_core #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_op,
    input  logic [W-1:0]  src_hi,
    input  logic [W-1:0]  divisor_in,
    input  logic [W-1:0]  src_lo,
    input  logic [CW-1:0] count_in,
    input  logic          zflag_en,
    output logic          busy,
    output logic [W-1:0]  quotient,
    output logic [W-1:0]  remainder,
    output logic [CW-1:0] count_out,
    output logic          zero_flag,
    output logic          div_zero_err
);
    import stepdiv_pkg::*;

    localparam logic [CW-1:0] CNT_MAX = CW'(W);

    typedef struct packed {
        stepdiv_state_e st;
        logic [W-1:0]   quo;
        logic [W-1:0]   rem;
        logic [W-1:0]   dvs;
        logic [W-1:0]   lo;
        logic [CW-1:0]  cnt;
        logic           zen;
        logic           zf;
        logic           err;
    } core_t;

    core_t cur_q, nxt_d;

    logic          idle;
    logic [W-1:0]  red_quo_in, red_rem_in, red_dvs_in;
    logic          red_hit;
    logic [W-1:0]  red_quo, red_rem;
    logic          sh_go;
    logic [W-1:0]  sh_quo, sh_rem;
    logic [CW-1:0] sh_cnt;
    logic [CW-1:0] cnt_clamp;

    assign idle       = (cur_q.st == ST_IDLE);
    assign red_quo_in = idle ? '0 : cur_q.quo;
    assign red_rem_in = idle ? src_hi : cur_q.rem;
    assign red_dvs_in = idle ? divisor_in : cur_q.dvs;
    assign cnt_clamp  = (count_in > CNT_MAX) ? CNT_MAX : count_in;

    stepdiv_reduce #(.W(W)) u_reduce (
        .quo_i (red_quo_in),
        .rem_i (red_rem_in),
        .dvs_i (red_dvs_in),
        .hit_o (red_hit),
        .quo_o (red_quo),
        .rem_o (red_rem)
    );

    stepdiv_shift #(.W(W), .CW(CW)) u_shift (
        .quo_i (cur_q.quo),
        .rem_i (cur_q.rem),
        .dvs_i (cur_q.dvs),
        .lo_i  (cur_q.lo),
        .cnt_i (cur_q.cnt),
        .go_o  (sh_go),
        .quo_o (sh_quo),
        .rem_o (sh_rem),
        .cnt_o (sh_cnt)
    );

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_op == OP_LOAD) begin
                        nxt_d.quo = red_quo;
                        nxt_d.rem = red_rem;
                        nxt_d.dvs = divisor_in;
                        nxt_d.err = (divisor_in == '0);
                    end else if (cnt_clamp == '0) begin
                        nxt_d.cnt = '0;
                        if (zflag_en) nxt_d.zf = 1'b1;
                    end else begin
                        nxt_d.lo  = src_lo;
                        nxt_d.cnt = cnt_clamp;
                        nxt_d.zen = zflag_en;
                        nxt_d.st  = ST_RUN;
                    end
                end
            end
            default: begin
                if (sh_go) begin
                    nxt_d.quo = sh_quo;
                    nxt_d.rem = sh_rem;
                    nxt_d.cnt = sh_cnt;
                end else begin
                    nxt_d.quo = red_quo;
                    nxt_d.rem = red_rem;
                    nxt_d.st  = ST_IDLE;
                    if (cur_q.zen) nxt_d.zf = (cur_q.cnt == '0);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy         = (cur_q.st == ST_RUN);
    assign quotient     = cur_q.quo;
    assign remainder    = cur_q.rem;
    assign count_out    = cur_q.cnt;
    assign zero_flag    = cur_q.zf;
    assign div_zero_err = cur_q.err;

    // R2: a load never starts a busy period
    p_load_no_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == OP_LOAD) |=> !busy);

    // R4: a nonzero-count step raises busy on the next cycle
    p_step_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == OP_STEP && count_in != '0) |=> busy);

    // R5: the remaining count never rises while busy
    p_cnt_nonincr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (count_out <= $past(count_out)));

    // R6: a zero-count step leaves quotient and remainder alone
    p_zero_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == OP_STEP && count_in == '0)
        |=> (!busy && $stable(quotient) && $stable(remainder) && count_out == '0));

    // R8: a zero divisor on load raises the error
    p_div_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == OP_LOAD && divisor_in == '0) |=> div_zero_err);

    // R9: the error output does not change during a step
    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(div_zero_err));

    // R3: a reduction never leaves the remainder larger than before
    p_reduce_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && red_hit && !sh_go) |=> (remainder < $past(remainder)));
endmodule

// File: tb/stepdiv_core_tb.sv
module stepdiv_core_tb_top;
    localparam int W  = 64;
    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_op = 1'b0;
    logic [W-1:0]  src_hi = '0;
    logic [W-1:0]  divisor_in = '0;
    logic [W-1:0]  src_lo = '0;
    logic [CW-1:0] count_in = '0;
    logic          zflag_en = 1'b0;
    logic          busy;
    logic [W-1:0]  quotient, remainder;
    logic [CW-1:0] count_out;
    logic          zero_flag, div_zero_err;

    stepdiv_core #(.W(W), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .src_hi(src_hi), .divisor_in(divisor_in), .src_lo(src_lo),
        .count_in(count_in), .zflag_en(zflag_en), .busy(busy),
        .quotient(quotient), .remainder(remainder), .count_out(count_out),
        .zero_flag(zero_flag), .div_zero_err(div_zero_err)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string tag = "R1";

    // reference model state
    logic [63:0] mq = 0, mr = 0, md = 0;
    int mcnt = 0;
    bit mzf = 0, merr = 0;
    int busy_left = 0;
    logic [63:0] pq, pr;
    int pcnt;
    bit pzf;

    function automatic void mreduce(inout logic [63:0] q, inout logic [63:0] r, input logic [63:0] d);
        int s;
        if (d != 0 && d <= r) begin
            s = 0;
            while (s < 63 && ((d << (s + 1)) >> (s + 1)) == d && (d << (s + 1)) <= r) s++;
            q = q + (64'd1 << s);
            r = r - (d << s);
        end
    endfunction

    task automatic chk(input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [63:0] q, r, lo;
        int c, k;
        if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) begin
                mq = pq; mr = pr; mcnt = pcnt; mzf = pzf;
            end
        end else if (cmd_valid) begin
            if (cmd_op == 1'b0) begin
                q = 0; r = src_hi;
                md = divisor_in;
                merr = (divisor_in == 0);
                mreduce(q, r, md);
                mq = q; mr = r;
            end else begin
                c = (int'(count_in) > W) ? W : int'(count_in);
                if (c == 0) begin
                    mcnt = 0;
                    if (zflag_en) mzf = 1;
                end else begin
                    q = mq; r = mr; lo = src_lo; k = 0;
                    while (r < md && c > 0) begin
                        r = (r << 1) | 64'(lo[c-1]);
                        q = q << 1;
                        c--; k++;
                    end
                    mreduce(q, r, md);
                    pq = q; pr = r; pcnt = c;
                    pzf = zflag_en ? (c == 0) : mzf;
                    busy_left = k + 1;
                end
            end
        end
    endtask

    task automatic compare_all();
        chk(tag, "busy", 64'(busy), 64'(busy_left > 0));
        if (busy_left == 0) begin
            chk(tag, "quotient", quotient, mq);
            chk(tag, "remainder", remainder, mr);
            chk(tag, "count", 64'(count_out), 64'(mcnt));
            chk(tag, "zero_flag", 64'(zero_flag), 64'(mzf));
            chk(tag, "div_zero_err", 64'(div_zero_err), 64'(merr));
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic issue(input logic op, input logic [63:0] hi, input logic [63:0] d,
                         input logic [63:0] lo, input int cnt, input logic zen);
        cmd_op = op; src_hi = hi; divisor_in = d; src_lo = lo;
        count_in = CW'(cnt); zflag_en = zen; cmd_valid = 1'b1;
        cycle();
        cmd_valid = 1'b0;
        while (busy_left > 0) cycle();
        cycle();
    endtask

    task automatic full_div(input logic [63:0] lo, input logic [63:0] d);
        int c;
        tag = "R10";
        issue(1'b0, 64'd0, d, 64'd0, 0, 1'b0);
        c = W;
        for (int i = 0; i < 70 && c != 0; i++) begin
            tag = "R4";
            issue(1'b1, 64'd0, 64'd0, lo, c, 1'b1);
            c = int'(count_out);
        end
        chk("R10", "final quotient", quotient, lo / d);
        chk("R10", "final remainder", remainder, lo % d);
        chk("R7", "zero flag at end", 64'(zero_flag), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        compare_all();
        chk("R1", "quotient after reset", quotient, 64'd0);

        tag = "R2";
        issue(1'b0, 64'd100, 64'd7, 64'd0, 0, 1'b0);
        chk("R3", "reduced quotient", quotient, 64'd8);
        chk("R3", "reduced remainder", remainder, 64'd44);

        tag = "R3";
        issue(1'b0, 64'd5, 64'd9, 64'd0, 0, 1'b0);
        chk("R3", "no-op reduction remainder", remainder, 64'd5);

        tag = "R6";
        issue(1'b1, 64'd0, 64'd0, 64'hFFFF, 0, 1'b1);
        chk("R6", "remainder kept", remainder, 64'd5);
        chk("R7", "zero flag set", 64'(zero_flag), 64'd1);

        full_div(64'd1000003, 64'd7);
        full_div(64'h0000_FFFF_FFFF_FFFF, 64'd12345);
        full_div(64'd12, 64'd12);
        full_div(64'd5, 64'd9);
        full_div(64'hDEAD_BEEF_0123_4567, 64'h1_0000_0001);

        // R7: step ending with a nonzero count clears the flag
        tag = "R7";
        issue(1'b0, 64'd0, 64'd1, 64'd0, 0, 1'b0);
        issue(1'b1, 64'd0, 64'd0, 64'h8000_0000_0000_0000, 64, 1'b1);
        chk("R7", "flag cleared", 64'(zero_flag), 64'd0);
        chk("R5", "count left", 64'(count_out), 64'd63);
        issue(1'b1, 64'd0, 64'd0, 64'd0, 0, 1'b0);
        chk("R7", "flag kept without enable", 64'(zero_flag), 64'd0);

        // R9: a load during a step is dropped
        tag = "R9";
        issue(1'b0, 64'd0, 64'd3, 64'd0, 0, 1'b0);
        cmd_op = 1'b1; src_lo = 64'h0123_4567; count_in = CW'(64); zflag_en = 1'b1; cmd_valid = 1'b1;
        cycle();
        cmd_op = 1'b0; src_hi = 64'd999; divisor_in = 64'd5;
        cycle();
        cmd_valid = 1'b0;
        while (busy_left > 0) cycle();
        cycle();
        chk("R9", "divisor kept", remainder < 64'd3 || count_out != 0 ? 64'd1 : 64'd0, 64'd1);

        // R8: zero divisor
        tag = "R8";
        issue(1'b0, 64'd77, 64'd0, 64'd0, 0, 1'b0);
        chk("R8", "error raised", 64'(div_zero_err), 64'd1);
        chk("R8", "remainder is upper dividend", remainder, 64'd77);
        issue(1'b1, 64'd0, 64'd0, 64'hF, 5, 1'b0);
        chk("R8", "error held", 64'(div_zero_err), 64'd1);
        issue(1'b0, 64'd4, 64'd3, 64'd0, 0, 1'b0);
        chk("R8", "error cleared", 64'(div_zero_err), 64'd0);

        // R11: count above W clamped
        tag = "R11";
        issue(1'b0, 64'd0, 64'd1, 64'd0, 0, 1'b0);
        issue(1'b1, 64'd0, 64'd0, 64'h4000_0000_0000_0000, 100, 1'b1);
        chk("R11", "clamped count", 64'(count_out), 64'd62);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule